// File: doc/BRIEF.md
# SPI Controller Register and FIFO Frontend

This block is the memory-mapped half of an SPI controller. An AXI-Lite subordinate port decodes five byte-wide registers: data, control, status, baud divider and chip select. A write to the data register queues a byte in a 16-entry transmit FIFO. A read of the data register takes the oldest byte out of a 16-entry receive FIFO. The control, baud and chip-select registers drive plain configuration pins toward the serial engine and the select lines.

Toward the shift engine the block offers a valid/ready stream of transmit bytes. A byte leaves the transmit FIFO on a cycle where both `eng_start_valid` and `eng_start_ready` are high. The engine holds `eng_start_ready` low to stall, and the frontend holds the byte stable meanwhile. Finished transfers come back as a one-cycle `eng_done` pulse carrying the received byte. That path has no back-pressure, so a byte that arrives when the receive FIFO is full is lost.

Status flags record transfer completion, write collision and mode fault. A level interrupt combines a receive-threshold condition, an empty transmit FIFO and the error flags.

Top module: `spi_axil_frontend`

## Requirements
- R1: After reset, reads return data 0x00, control 0x00, status 0x02, baud 0x02 and chip select 0xFF. `irq` is low, `cs_n` is 0xFF and `eng_start_valid` is low.
- R2: Register n sits at byte address 4n: data 0, control 1, status 2, baud 3, chip select 4. Address bits 1:0 are ignored. Control, baud and chip select read back the low byte last written. Read data bits 31:8 are always 0. `cfg_baud` and `cs_n` follow their registers.
- R3: The write address and the write data may arrive in either order or together, and each write gets exactly one response. A raised `s_bvalid` or `s_rvalid` stays high, with `s_bresp`, `s_rdata` and `s_rresp` unchanged, until it is accepted.
- R4: Register indexes 5 to 7 are unmapped. A write to one gets SLVERR (2'b10) and changes nothing. A read of one gets SLVERR and data 0. Mapped addresses get OKAY (2'b00).
- R5: Data writes are queued in a 16-entry transmit FIFO. Bytes leave on the start stream in write order. `eng_start_valid` is high only while control bit 0 (enable) is set and the FIFO holds a byte.
- R6: A data write while the transmit FIFO holds 16 bytes is dropped and sets the write-collision flag.
- R7: Each `eng_done` pulse pushes `eng_rx_byte` into a 16-entry receive FIFO; the byte is dropped if the FIFO is full. Data reads return the bytes in arrival order. A data read with the FIFO empty returns 0.
- R8: The status bits are: bit 0 transfer complete (set by `eng_done`), bit 1 transmit FIFO empty, bit 2 write collision, bit 3 mode fault (set by `eng_mode_fault`), bit 4 receive FIFO not empty, bit 5 transmit FIFO full. Writing 1 clears bits 0, 2 and 3. Writing 0 leaves them unchanged.
- R9: The control fields are: bit 0 enable, bit 1 master select, bit 2 clock polarity, bit 3 clock phase, bits 7:4 receive threshold. The first four fields appear on `cfg_enable`, `cfg_master`, `cfg_cpol` and `cfg_cpha`.
- R10: `irq` is high exactly when at least one of these holds:
  - the threshold is nonzero and the receive count is at least the threshold;
  - enable is set and the transmit FIFO is empty;
  - write collision is set;
  - mode fault is set.
- R11: A write with `s_axil_wstrb[0]` low changes no register, pushes nothing into the transmit FIFO, and still gets OKAY.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_axil_awaddr | input | ADDR_W | Write address |
| s_axil_awvalid | input | 1 | Write address valid |
| s_axil_awready | output | 1 | Write address ready |
| s_axil_wdata | input | DATA_W | Write data |
| s_axil_wstrb | input | DATA_W/8 | Write strobes; only lane 0 is used |
| s_axil_wvalid | input | 1 | Write data valid |
| s_axil_wready | output | 1 | Write data ready |
| s_axil_bresp | output | 2 | Write response |
| s_axil_bvalid | output | 1 | Write response valid |
| s_axil_bready | input | 1 | Write response ready |
| s_axil_araddr | input | ADDR_W | Read address |
| s_axil_arvalid | input | 1 | Read address valid |
| s_axil_arready | output | 1 | Read address ready |
| s_axil_rdata | output | DATA_W | Read data |
| s_axil_rresp | output | 2 | Read response |
| s_axil_rvalid | output | 1 | Read data valid |
| s_axil_rready | input | 1 | Read data ready |
| eng_start_valid | output | 1 | A transmit byte is offered to the engine |
| eng_start_ready | input | 1 | Engine accepts the offered byte |
| eng_tx_byte | output | 8 | Byte offered to the engine |
| eng_done | input | 1 | One-cycle pulse: a transfer finished |
| eng_rx_byte | input | 8 | Byte received by the finished transfer |
| eng_mode_fault | input | 1 | One-cycle pulse: the engine saw a mode fault |
| cfg_enable | output | 1 | Control enable bit |
| cfg_master | output | 1 | Control master select bit |
| cfg_cpol | output | 1 | Control clock polarity bit |
| cfg_cpha | output | 1 | Control clock phase bit |
| cfg_baud | output | 8 | Baud divider register |
| cs_n | output | 8 | Chip-select register, active-low lines |
| irq | output | 1 | Level interrupt |

## Verification
The response-hold properties assume the manager drops a valid only after its handshake. They also assume it does not present a new write until the previous response has been taken. The bench tasks raise one valid at a time, hold it until the matching ready has been seen, and wait for each response before the next request.

The engine-side properties assume `eng_done` and `eng_mode_fault` are single-cycle pulses. The bench engine model drives each of them for exactly one cycle, and it raises `eng_start_ready` only while a byte is offered.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
  localparam int REG_IDX_W = 3;
  localparam int NUM_REGS  = 5;

  typedef enum logic [REG_IDX_W-1:0] {
    IDX_DATA = 3'd0,
    IDX_CTRL = 3'd1,
    IDX_STAT = 3'd2,
    IDX_BAUD = 3'd3,
    IDX_CSEL = 3'd4
  } reg_idx_e;

  localparam logic [7:0] CTRL_RST = 8'h00;
  localparam logic [7:0] BAUD_RST = 8'h02;
  localparam logic [7:0] CSEL_RST = 8'hFF;

  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;

  // status bit positions
  localparam int ST_DONE = 0;
  localparam int ST_TXE  = 1;
  localparam int ST_WCOL = 2;
  localparam int ST_MODF = 3;
  localparam int ST_RXNE = 4;
  localparam int ST_TXF  = 5;
endpackage

// File: rtl/spi_fe_fifo.sv
module spi_fe_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [WIDTH-1:0]             push_data,
  input  logic                         pop,
  output logic [WIDTH-1:0]             head,
  output logic                         empty,
  output logic                         full,
  output logic [$clog2(DEPTH+1)-1:0]   count
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wp_q, rp_q;
  logic [CNT_W-1:0] cnt_q;
  logic do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rp_q];
  assign count   = cnt_q;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wp_q <= (wp_q == LAST) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_q <= (rp_q == LAST) ? '0 : rp_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/spi_fe_axil_port.sv
module spi_fe_axil_port
  import spi_fe_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [ADDR_W-1:0]      awaddr,
  input  logic                   awvalid,
  output logic                   awready,
  input  logic [DATA_W-1:0]      wdata,
  input  logic [DATA_W/8-1:0]    wstrb,
  input  logic                   wvalid,
  output logic                   wready,
  output logic [1:0]             bresp,
  output logic                   bvalid,
  input  logic                   bready,
  input  logic [ADDR_W-1:0]      araddr,
  input  logic                   arvalid,
  output logic                   arready,
  output logic [DATA_W-1:0]      rdata,
  output logic [1:0]             rresp,
  output logic                   rvalid,
  input  logic                   rready,
  output logic                   wr_fire,
  output logic                   wr_mapped,
  output logic [REG_IDX_W-1:0]   wr_idx,
  output logic [7:0]             wr_byte,
  output logic                   wr_lane0,
  output logic                   rd_fire,
  output logic                   rd_mapped,
  output logic [REG_IDX_W-1:0]   rd_idx,
  input  logic [7:0]             rd_byte
);
  localparam int WORD_W = ADDR_W - 2;

  logic              aw_held_q, w_held_q, bvalid_q, rvalid_q;
  logic [WORD_W-1:0] aw_word_q;
  logic [7:0]        w_byte_q;
  logic              w_lane0_q;
  logic [1:0]        bresp_q, rresp_q;
  logic [DATA_W-1:0] rdata_q;
  logic [WORD_W-1:0] ar_word;
  logic              unused_bits;

  function automatic logic is_mapped(input logic [WORD_W-1:0] w);
    return w < WORD_W'(NUM_REGS);
  endfunction

  assign unused_bits = ^{awaddr[1:0], araddr[1:0], wdata[DATA_W-1:8], wstrb[DATA_W/8-1:1]};

  assign awready   = !aw_held_q;
  assign wready    = !w_held_q;
  assign wr_fire   = aw_held_q && w_held_q && !bvalid_q;
  assign wr_mapped = is_mapped(aw_word_q);
  assign wr_idx    = aw_word_q[REG_IDX_W-1:0];
  assign wr_byte   = w_byte_q;
  assign wr_lane0  = w_lane0_q;

  assign ar_word   = araddr[ADDR_W-1:2];
  assign arready   = !rvalid_q;
  assign rd_fire   = arvalid && !rvalid_q;
  assign rd_mapped = is_mapped(ar_word);
  assign rd_idx    = ar_word[REG_IDX_W-1:0];

  assign bvalid = bvalid_q;
  assign bresp  = bresp_q;
  assign rvalid = rvalid_q;
  assign rresp  = rresp_q;
  assign rdata  = rdata_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aw_held_q <= 1'b0;
      aw_word_q <= '0;
      w_held_q  <= 1'b0;
      w_byte_q  <= '0;
      w_lane0_q <= 1'b0;
      bvalid_q  <= 1'b0;
      bresp_q   <= RESP_OKAY;
    end else begin
      if (awvalid && awready) begin
        aw_held_q <= 1'b1;
        aw_word_q <= awaddr[ADDR_W-1:2];
      end
      if (wvalid && wready) begin
        w_held_q  <= 1'b1;
        w_byte_q  <= wdata[7:0];
        w_lane0_q <= wstrb[0];
      end
      if (wr_fire) begin
        aw_held_q <= 1'b0;
        w_held_q  <= 1'b0;
        bvalid_q  <= 1'b1;
        bresp_q   <= wr_mapped ? RESP_OKAY : RESP_SLVERR;
      end else if (bready) begin
        bvalid_q  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rresp_q  <= RESP_OKAY;
      rdata_q  <= '0;
    end else if (rd_fire) begin
      rvalid_q <= 1'b1;
      rresp_q  <= rd_mapped ? RESP_OKAY : RESP_SLVERR;
      rdata_q  <= rd_mapped ? DATA_W'(rd_byte) : '0;
    end else if (rready) begin
      rvalid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/spi_axil_frontend.sv
module spi_axil_frontend
  import spi_fe_pkg::*;
#(
  parameter int ADDR_W     = 5,
  parameter int DATA_W     = 32,
  parameter int FIFO_DEPTH = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   s_axil_awaddr,
  input  logic                s_axil_awvalid,
  output logic                s_axil_awready,
  input  logic [DATA_W-1:0]   s_axil_wdata,
  input  logic [DATA_W/8-1:0] s_axil_wstrb,
  input  logic                s_axil_wvalid,
  output logic                s_axil_wready,
  output logic [1:0]          s_axil_bresp,
  output logic                s_axil_bvalid,
  input  logic                s_axil_bready,
  input  logic [ADDR_W-1:0]   s_axil_araddr,
  input  logic                s_axil_arvalid,
  output logic                s_axil_arready,
  output logic [DATA_W-1:0]   s_axil_rdata,
  output logic [1:0]          s_axil_rresp,
  output logic                s_axil_rvalid,
  input  logic                s_axil_rready,
  output logic                eng_start_valid,
  input  logic                eng_start_ready,
  output logic [7:0]          eng_tx_byte,
  input  logic                eng_done,
  input  logic [7:0]          eng_rx_byte,
  input  logic                eng_mode_fault,
  output logic                cfg_enable,
  output logic                cfg_master,
  output logic                cfg_cpol,
  output logic                cfg_cpha,
  output logic [7:0]          cfg_baud,
  output logic [7:0]          cs_n,
  output logic                irq
);
  localparam int CNT_W = $clog2(FIFO_DEPTH+1);

  logic                 wr_fire, wr_mapped, wr_lane0, rd_fire, rd_mapped;
  logic [REG_IDX_W-1:0] wr_idx, rd_idx;
  logic [7:0]           wr_byte, rd_byte;

  logic [7:0] ctrl_q, baud_q, csel_q;
  logic       done_q, wcol_q, modf_q;

  logic             tx_push, tx_pop, tx_empty, tx_full;
  logic [7:0]       tx_head;
  logic [CNT_W-1:0] tx_count;
  logic             rx_pop, rx_empty, rx_full;
  logic [7:0]       rx_head;
  logic [CNT_W-1:0] rx_count;

  logic       wr_go, stat_wr, data_rd;
  logic [3:0] rx_thr;
  logic [7:0] status_v;

  spi_fe_axil_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
    .clk(clk), .rst_n(rst_n),
    .awaddr(s_axil_awaddr), .awvalid(s_axil_awvalid), .awready(s_axil_awready),
    .wdata(s_axil_wdata), .wstrb(s_axil_wstrb), .wvalid(s_axil_wvalid), .wready(s_axil_wready),
    .bresp(s_axil_bresp), .bvalid(s_axil_bvalid), .bready(s_axil_bready),
    .araddr(s_axil_araddr), .arvalid(s_axil_arvalid), .arready(s_axil_arready),
    .rdata(s_axil_rdata), .rresp(s_axil_rresp), .rvalid(s_axil_rvalid), .rready(s_axil_rready),
    .wr_fire(wr_fire), .wr_mapped(wr_mapped), .wr_idx(wr_idx), .wr_byte(wr_byte),
    .wr_lane0(wr_lane0), .rd_fire(rd_fire), .rd_mapped(rd_mapped), .rd_idx(rd_idx),
    .rd_byte(rd_byte)
  );

  assign wr_go   = wr_fire && wr_mapped && wr_lane0;
  assign stat_wr = wr_go && (wr_idx == IDX_STAT);
  assign tx_push = wr_go && (wr_idx == IDX_DATA);
  assign data_rd = rd_fire && rd_mapped && (rd_idx == IDX_DATA);
  assign rx_pop  = data_rd;
  assign tx_pop  = eng_start_valid && eng_start_ready;

  spi_fe_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .push_data(wr_byte), .pop(tx_pop),
    .head(tx_head), .empty(tx_empty), .full(tx_full), .count(tx_count)
  );

  spi_fe_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(eng_done), .push_data(eng_rx_byte), .pop(rx_pop),
    .head(rx_head), .empty(rx_empty), .full(rx_full), .count(rx_count)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= CTRL_RST;
      baud_q <= BAUD_RST;
      csel_q <= CSEL_RST;
    end else if (wr_go) begin
      case (wr_idx)
        IDX_CTRL: ctrl_q <= wr_byte;
        IDX_BAUD: baud_q <= wr_byte;
        IDX_CSEL: csel_q <= wr_byte;
        default:  ;
      endcase
    end
  end

  // sticky flags: a set in the same cycle as a clear wins
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      wcol_q <= 1'b0;
      modf_q <= 1'b0;
    end else begin
      done_q <= eng_done | (done_q & ~(stat_wr & wr_byte[ST_DONE]));
      wcol_q <= (tx_push & tx_full) | (wcol_q & ~(stat_wr & wr_byte[ST_WCOL]));
      modf_q <= eng_mode_fault | (modf_q & ~(stat_wr & wr_byte[ST_MODF]));
    end
  end

  always_comb begin
    status_v          = '0;
    status_v[ST_DONE] = done_q;
    status_v[ST_TXE]  = tx_empty;
    status_v[ST_WCOL] = wcol_q;
    status_v[ST_MODF] = modf_q;
    status_v[ST_RXNE] = !rx_empty;
    status_v[ST_TXF]  = tx_full;
  end

  always_comb begin
    case (rd_idx)
      IDX_DATA: rd_byte = rx_empty ? 8'h00 : rx_head;
      IDX_CTRL: rd_byte = ctrl_q;
      IDX_STAT: rd_byte = status_v;
      IDX_BAUD: rd_byte = baud_q;
      IDX_CSEL: rd_byte = csel_q;
      default:  rd_byte = 8'h00;
    endcase
  end

  assign rx_thr          = ctrl_q[7:4];
  assign cfg_enable      = ctrl_q[0];
  assign cfg_master      = ctrl_q[1];
  assign cfg_cpol        = ctrl_q[2];
  assign cfg_cpha        = ctrl_q[3];
  assign cfg_baud        = baud_q;
  assign cs_n            = csel_q;
  assign eng_start_valid = cfg_enable && !tx_empty;
  assign eng_tx_byte     = tx_head;

  assign irq = ((rx_thr != 4'd0) && (rx_count >= CNT_W'(rx_thr)))
             | (cfg_enable && tx_empty)
             | wcol_q | modf_q;
endmodule

// File: rtl/spi_fe_checks.sv
module spi_fe_checks #(
  parameter int CNT_W      = 5,
  parameter int FIFO_DEPTH = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bvalid,
  input logic             bready,
  input logic [1:0]       bresp,
  input logic             rvalid,
  input logic             rready,
  input logic [31:0]      rdata,
  input logic [1:0]       rresp,
  input logic             start_valid,
  input logic             start_ready,
  input logic [7:0]       start_byte,
  input logic             enable,
  input logic [CNT_W-1:0] tx_count,
  input logic [CNT_W-1:0] rx_count,
  input logic             wr_fire,
  input logic             wr_mapped,
  input logic             wr_lane0,
  input logic [2:0]       wr_idx,
  input logic             wcol,
  input logic             modf,
  input logic             irq
);
  assert_bvalid_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid && !bready |=> bvalid && $stable(bresp));

  assert_rvalid_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid && !rready |=> rvalid && $stable(rdata) && $stable(rresp));

  assert_rdata_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> rdata[31:8] == 24'h0);

  assert_tx_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_count <= CNT_W'(FIFO_DEPTH));

  assert_start_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start_valid |-> enable && (tx_count != '0));

  assert_start_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start_valid && !start_ready && enable |=> start_valid && $stable(start_byte));

  assert_rx_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= CNT_W'(FIFO_DEPTH));

  assert_wcol_on_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire && wr_mapped && wr_lane0 && (wr_idx == 3'd0) && (tx_count == CNT_W'(FIFO_DEPTH))
    |=> wcol);

  assert_err_irq_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wcol || modf) |-> irq);
endmodule

bind spi_axil_frontend spi_fe_checks #(.CNT_W(CNT_W), .FIFO_DEPTH(FIFO_DEPTH)) u_checks (
  .clk(clk), .rst_n(rst_n),
  .bvalid(s_axil_bvalid), .bready(s_axil_bready), .bresp(s_axil_bresp),
  .rvalid(s_axil_rvalid), .rready(s_axil_rready), .rdata(s_axil_rdata), .rresp(s_axil_rresp),
  .start_valid(eng_start_valid), .start_ready(eng_start_ready), .start_byte(eng_tx_byte),
  .enable(cfg_enable), .tx_count(tx_count), .rx_count(rx_count),
  .wr_fire(wr_fire), .wr_mapped(wr_mapped), .wr_lane0(wr_lane0), .wr_idx(wr_idx),
  .wcol(wcol_q), .modf(modf_q), .irq(irq)
);

// File: tb/sim_spi_axil_frontend.sv
module sim_spi_axil_frontend;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [4:0]  awaddr = '0, araddr = '0;
  logic        awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
  logic [31:0] wdata = '0;
  logic [3:0]  wstrb = '0;
  logic        awready, wready, bvalid, arready, rvalid;
  logic [1:0]  bresp, rresp;
  logic [31:0] rdata;
  logic        start_valid, start_ready = 0;
  logic [7:0]  tx_byte;
  logic        done = 0, mode_fault = 0;
  logic [7:0]  rx_byte = '0;
  logic        enable, master, cpol, cpha, irq;
  logic [7:0]  baud, csn;

  int nchk = 0, nfail = 0;

  spi_axil_frontend u0 (
    .clk(clk), .rst_n(rst_n),
    .s_axil_awaddr(awaddr), .s_axil_awvalid(awvalid), .s_axil_awready(awready),
    .s_axil_wdata(wdata), .s_axil_wstrb(wstrb), .s_axil_wvalid(wvalid), .s_axil_wready(wready),
    .s_axil_bresp(bresp), .s_axil_bvalid(bvalid), .s_axil_bready(bready),
    .s_axil_araddr(araddr), .s_axil_arvalid(arvalid), .s_axil_arready(arready),
    .s_axil_rdata(rdata), .s_axil_rresp(rresp), .s_axil_rvalid(rvalid), .s_axil_rready(rready),
    .eng_start_valid(start_valid), .eng_start_ready(start_ready), .eng_tx_byte(tx_byte),
    .eng_done(done), .eng_rx_byte(rx_byte), .eng_mode_fault(mode_fault),
    .cfg_enable(enable), .cfg_master(master), .cfg_cpol(cpol), .cfg_cpha(cpha),
    .cfg_baud(baud), .cs_n(csn), .irq(irq)
  );

  task automatic chk(input string req, input string what, input logic [31:0] got,
                     input logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // order: 0 together, 1 address first, 2 data first; bdelay cycles of withheld bready
  task automatic axi_write(input logic [4:0] a, input logic [31:0] d, input logic [3:0] s,
                           input int order, input int bdelay, output logic [1:0] resp);
    logic aw_todo, w_todo, acc_a, acc_w;
    aw_todo = 1; w_todo = 1;
    awaddr = a; wdata = d; wstrb = s;
    while (aw_todo || w_todo) begin
      awvalid = aw_todo && !(order == 2 && w_todo);
      wvalid  = w_todo && !(order == 1 && aw_todo);
      #1;
      acc_a = awvalid && awready;
      acc_w = wvalid && wready;
      @(posedge clk); #1;
      if (acc_a) aw_todo = 0;
      if (acc_w) w_todo = 0;
    end
    awvalid = 0; wvalid = 0;
    while (!bvalid) begin @(posedge clk); #1; end
    for (int i = 0; i < bdelay; i++) begin
      @(posedge clk); #1;
      chk("R3", "bvalid held while bready low", {31'b0, bvalid}, 32'd1);
    end
    resp = bresp;
    bready = 1;
    @(posedge clk); #1;
    bready = 0;
  endtask

  task automatic axi_read(input logic [4:0] a, output logic [31:0] d, output logic [1:0] resp);
    logic acc;
    araddr = a; arvalid = 1;
    acc = 0;
    while (!acc) begin
      #1; acc = arready;
      @(posedge clk); #1;
    end
    arvalid = 0;
    while (!rvalid) begin @(posedge clk); #1; end
    d = rdata; resp = rresp;
    rready = 1;
    @(posedge clk); #1;
    rready = 0;
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    logic [1:0] r;
    axi_write(5'(idx * 4), d, 4'hF, 0, 0, r);
  endtask

  task automatic rd_chk(input string req, input string what, input int idx,
                        input logic [31:0] exp);
    logic [31:0] d; logic [1:0] r;
    axi_read(5'(idx * 4), d, r);
    chk(req, what, d, exp);
  endtask

  task automatic pulse_done(input logic [7:0] b);
    rx_byte = b; done = 1;
    @(posedge clk); #1;
    done = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [31:0] d; logic [1:0] r;
    repeat (4) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;

    // R1 reset values
    chk("R1", "irq", {31'b0, irq}, 0);
    chk("R1", "cs_n", {24'b0, csn}, 32'hFF);
    chk("R1", "start_valid", {31'b0, start_valid}, 0);
    rd_chk("R1", "data", 0, 32'h00);
    rd_chk("R1", "control", 1, 32'h00);
    rd_chk("R1", "status", 2, 32'h02);
    rd_chk("R1", "baud", 3, 32'h02);
    rd_chk("R1", "chip select", 4, 32'hFF);

    // R2 readback, ignored low address bits, upper data bits
    wr(3, 32'hFFFF_FF37);
    chk("R2", "cfg_baud", {24'b0, baud}, 32'h37);
    axi_read(5'd14, d, r);
    chk("R2", "baud via offset 14", d, 32'h37);
    for (int v = 0; v < 256; v += 17) begin
      wr(4, 32'(v));
      chk("R2", "cs_n pin", {24'b0, csn}, 32'(v));
      rd_chk("R2", "chip select readback", 4, 32'(v));
    end

    // R4 unmapped indexes
    for (int i = 5; i < 8; i++) begin
      axi_write(5'(i * 4), 32'h00, 4'hF, 0, 0, r);
      chk("R4", "write resp", {30'b0, r}, 32'd2);
      axi_read(5'(i * 4), d, r);
      chk("R4", "read resp", {30'b0, r}, 32'd2);
      chk("R4", "read data", d, 0);
    end
    rd_chk("R4", "baud untouched", 3, 32'h37);
    axi_read(5'd4, d, r);
    chk("R4", "mapped read OKAY", {30'b0, r}, 0);

    // R3 ordering and response hold
    axi_write(5'd16, 32'h5A, 4'hF, 1, 0, r);
    chk("R3", "aw-first resp", {30'b0, r}, 0);
    rd_chk("R3", "aw-first effect", 4, 32'h5A);
    axi_write(5'd16, 32'hC3, 4'hF, 2, 3, r);
    chk("R3", "w-first resp", {30'b0, r}, 0);
    rd_chk("R3", "w-first effect", 4, 32'hC3);

    // R11 strobe lane 0 low
    axi_write(5'd12, 32'h99, 4'hE, 0, 0, r);
    chk("R11", "resp", {30'b0, r}, 0);
    rd_chk("R11", "baud unchanged", 3, 32'h37);
    axi_write(5'd0, 32'h99, 4'h0, 0, 0, r);
    rd_chk("R11", "no tx push", 2, 32'h02);

    // R5/R6 fill transmit FIFO with enable off
    for (int k = 0; k < 16; k++) wr(0, 32'(8'(k * 7 + 3)));
    chk("R5", "start_valid while disabled", {31'b0, start_valid}, 0);
    rd_chk("R8", "status full", 2, 32'h20);
    chk("R10", "irq quiet", {31'b0, irq}, 0);
    wr(0, 32'hEE);
    rd_chk("R6", "collision flag", 2, 32'h24);
    chk("R10", "irq on collision", {31'b0, irq}, 1);
    wr(2, 32'h00);
    rd_chk("R8", "write 0 keeps flag", 2, 32'h24);
    wr(2, 32'h04);
    rd_chk("R8", "W1C collision", 2, 32'h20);
    chk("R10", "irq cleared", {31'b0, irq}, 0);

    // R5 drain in order
    wr(1, 32'h01);
    chk("R9", "cfg_enable", {31'b0, enable}, 1);
    for (int k = 0; k < 16; k++) begin
      while (!start_valid) begin @(posedge clk); #1; end
      chk("R5", "tx order", {24'b0, tx_byte}, 32'(8'(k * 7 + 3)));
      start_ready = 1;
      @(posedge clk); #1;
      start_ready = 0;
    end
    chk("R5", "start_valid after drain", {31'b0, start_valid}, 0);
    rd_chk("R8", "status empty", 2, 32'h02);
    chk("R10", "irq tx empty while enabled", {31'b0, irq}, 1);

    // R9 control fields
    wr(1, 32'h0E);
    chk("R9", "enable", {31'b0, enable}, 0);
    chk("R9", "master", {31'b0, master}, 1);
    chk("R9", "cpol", {31'b0, cpol}, 1);
    chk("R9", "cpha", {31'b0, cpha}, 1);
    chk("R10", "irq tx empty while disabled", {31'b0, irq}, 0);

    // R7/R10 receive fill with threshold sweep
    for (int c = 1; c <= 16; c++) begin
      pulse_done(8'hC0 ^ 8'(c));
      for (int t = 1; t < 16; t++) begin
        wr(1, 32'(t << 4));
        chk("R10", "threshold irq", {31'b0, irq}, (c >= t) ? 1 : 0);
      end
    end
    wr(1, 32'h00);
    rd_chk("R8", "status complete and rx", 2, 32'h13);
    pulse_done(8'h55);
    wr(2, 32'h01);
    rd_chk("R8", "W1C complete", 2, 32'h12);
    for (int c = 1; c <= 16; c++)
      rd_chk("R7", "rx order", 0, 32'(8'hC0 ^ 8'(c)));
    rd_chk("R7", "empty read", 0, 0);
    rd_chk("R8", "status drained", 2, 32'h02);

    // R8/R10 mode fault
    mode_fault = 1; @(posedge clk); #1; mode_fault = 0;
    rd_chk("R8", "mode fault", 2, 32'h0A);
    chk("R10", "irq on mode fault", {31'b0, irq}, 1);
    wr(2, 32'h08);
    rd_chk("R8", "W1C mode fault", 2, 32'h02);
    chk("R10", "irq idle", {31'b0, irq}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule